// File: doc/BRIEF.md
# Mode-Selected Ripple ALU

This block is a purely combinational arithmetic/logic unit of configurable width (four bits by default). A mode input chooses between two families of operations. With the mode low, a three-bit function select picks one of eight bitwise operations, including the two constant outputs. With the mode high, only the lower two select bits matter and they pick one of four arithmetic operations: increment, add, subtract and decrement.

Internally the result comes from a row of identical one-bit slices joined by a ripple carry chain. A small decoder turns the mode and select inputs into slice controls and a bit-0 carry. Subtraction is done as the first operand plus the complement of the second plus one. Decrement is done as the first operand plus an all-ones word. The external carry input only takes part in the add operation, so that several units can be chained for wider sums. The carry output is the raw carry leaving the top slice in arithmetic mode, and it is held low in logic mode.

Top module: `mdsel_alu`

## Requirements
- R1: With mode=0, func_sel=3'b000 gives a result of all zeros and func_sel=3'b111 gives a result of all ones, whatever the operands are.
- R2: With mode=0, func_sel=3'b001 gives opa OR opb and func_sel=3'b010 gives opa AND opb, bit by bit.
- R3: With mode=0, func_sel=3'b011 gives NOT opa and func_sel=3'b100 gives NOT opb.
- R4: With mode=0, func_sel=3'b101 gives NOT(opa AND opb) and func_sel=3'b110 gives NOT(opa OR opb).
- R5: With mode=0, carry_out is 0 and carry_in has no effect on the result.
- R6: With mode=1 and func_sel[1:0]=2'b00, {carry_out,result} equals opa+1 taken over WIDTH+1 bits. carry_in has no effect.
- R7: With mode=1 and func_sel[1:0]=2'b01, {carry_out,result} equals opa+opb+carry_in taken over WIDTH+1 bits.
- R8: With mode=1 and func_sel[1:0]=2'b10, {carry_out,result} equals opa + (NOT opb) + 1 taken over WIDTH+1 bits. carry_out is therefore 1 exactly when opa >= opb unsigned, and carry_in has no effect.
- R9: With mode=1 and func_sel[1:0]=2'b11, {carry_out,result} equals opa + all-ones taken over WIDTH+1 bits. The result is opa-1 modulo 2^WIDTH and carry_out is 1 exactly when opa is nonzero. carry_in has no effect.
- R10: With mode=1, func_sel[2] has no effect on result or carry_out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | WIDTH | First operand |
| opb | input | WIDTH | Second operand |
| mode | input | 1 | 0 selects a logic operation, 1 selects an arithmetic operation |
| func_sel | input | 3 | Operation select. All three bits are used in logic mode; only bits 1:0 are used in arithmetic mode |
| carry_in | input | 1 | Carry into bit 0, used only by the add operation |
| result | output | WIDTH | Operation result |
| carry_out | output | 1 | Carry out of the top slice in arithmetic mode, 0 in logic mode |

## Verification
The checker relies on every input holding a known 0 or 1 value whenever it is evaluated. It also relies on the inputs being stable for long enough that the ripple chain has settled before the ports are compared. The bench drives the operands, mode, select and carry as fully defined values on the falling clock edge and samples one nanosecond later. With the default width, every operand pair and both carry-in values are applied for each operation, so no undefined or half-settled combination ever reaches the checks.

// File: rtl/mdsel_alu_pkg.sv
package mdsel_alu_pkg;

  // What the arithmetic path adds to opa, bit by bit
  typedef enum logic [1:0] {
    ADDEND_ZERO = 2'b00,
    ADDEND_B    = 2'b01,
    ADDEND_NB   = 2'b10,
    ADDEND_ONES = 2'b11
  } addend_e;

  // Bitwise function codes, logic mode
  typedef enum logic [2:0] {
    LFN_ZERO = 3'b000,
    LFN_OR   = 3'b001,
    LFN_AND  = 3'b010,
    LFN_NA   = 3'b011,
    LFN_NB   = 3'b100,
    LFN_NAND = 3'b101,
    LFN_NOR  = 3'b110,
    LFN_ONES = 3'b111
  } lfn_e;

  // Controls shared by every slice
  typedef struct packed {
    logic    arith;
    lfn_e    lfn;
    addend_e addend;
  } slice_ctl_t;

endpackage

// File: rtl/mdsel_alu_decode.sv
module mdsel_alu_decode
  import mdsel_alu_pkg::*;
(
  input  logic       mode,
  input  logic [2:0] func_sel,
  output slice_ctl_t ctl,
  output logic       c0_ext,
  output logic       c0_val
);

  always_comb begin
    ctl.arith  = mode;
    ctl.lfn    = lfn_e'(func_sel);
    ctl.addend = ADDEND_ZERO;
    c0_ext     = 1'b0;
    c0_val     = 1'b0;
    if (mode) begin
      unique case (func_sel[1:0])
        2'b00: begin ctl.addend = ADDEND_ZERO; c0_val = 1'b1; end
        2'b01: begin ctl.addend = ADDEND_B;    c0_ext = 1'b1; end
        2'b10: begin ctl.addend = ADDEND_NB;   c0_val = 1'b1; end
        default: begin ctl.addend = ADDEND_ONES; c0_val = 1'b0; end
      endcase
    end
  end

endmodule

// File: rtl/mdsel_alu_slice.sv
module mdsel_alu_slice
  import mdsel_alu_pkg::*;
(
  input  logic       a_bit,
  input  logic       b_bit,
  input  slice_ctl_t ctl,
  input  logic       c_in,
  output logic       f_bit,
  output logic       c_out
);

  logic y_bit;
  logic half;
  logic sum_bit;
  logic lres;

  always_comb begin
    unique case (ctl.addend)
      ADDEND_ZERO: y_bit = 1'b0;
      ADDEND_B:    y_bit = b_bit;
      ADDEND_NB:   y_bit = ~b_bit;
      default:     y_bit = 1'b1;
    endcase
  end

  assign half    = a_bit ^ y_bit;
  assign sum_bit = half ^ c_in;
  assign c_out   = (a_bit & y_bit) | (half & c_in);

  always_comb begin
    unique case (ctl.lfn)
      LFN_ZERO: lres = 1'b0;
      LFN_OR:   lres = a_bit | b_bit;
      LFN_AND:  lres = a_bit & b_bit;
      LFN_NA:   lres = ~a_bit;
      LFN_NB:   lres = ~b_bit;
      LFN_NAND: lres = ~(a_bit & b_bit);
      LFN_NOR:  lres = ~(a_bit | b_bit);
      default:  lres = 1'b1;
    endcase
  end

  assign f_bit = ctl.arith ? sum_bit : lres;

endmodule

// File: rtl/mdsel_alu.sv
module mdsel_alu
  import mdsel_alu_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic             mode,
  input  logic [2:0]       func_sel,
  input  logic             carry_in,
  output logic [WIDTH-1:0] result,
  output logic             carry_out
);

  localparam int CHAIN = WIDTH + 1;

  slice_ctl_t       ctl;
  logic             c0_ext;
  logic             c0_val;
  logic [CHAIN-1:0] carry;

  mdsel_alu_decode dec_i (
    .mode     (mode),
    .func_sel (func_sel),
    .ctl      (ctl),
    .c0_ext   (c0_ext),
    .c0_val   (c0_val)
  );

  assign carry[0] = c0_ext ? carry_in : c0_val;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    mdsel_alu_slice slice_i (
      .a_bit (opa[i]),
      .b_bit (opb[i]),
      .ctl   (ctl),
      .c_in  (carry[i]),
      .f_bit (result[i]),
      .c_out (carry[i+1])
    );
  end

  assign carry_out = ctl.arith & carry[CHAIN-1];

endmodule

// File: rtl/mdsel_alu_chk.sv
module mdsel_alu_chk #(
  parameter int WIDTH = 4
) (
  input logic [WIDTH-1:0] opa,
  input logic [WIDTH-1:0] opb,
  input logic             mode,
  input logic [2:0]       func_sel,
  input logic             carry_in,
  input logic [WIDTH-1:0] result,
  input logic             carry_out
);

  logic [WIDTH:0] wide_a;
  logic [WIDTH:0] wide_b;
  logic [WIDTH:0] ref_add;
  logic [WIDTH:0] ref_inc;
  logic [WIDTH:0] got;

  always_comb begin
    wide_a  = {1'b0, opa};
    wide_b  = {1'b0, opb};
    ref_add = wide_a + wide_b + {{WIDTH{1'b0}}, carry_in};
    ref_inc = wide_a + {{WIDTH{1'b0}}, 1'b1};
    got     = {carry_out, result};
  end

  always_comb begin
    if (!mode) begin
      assert_logic_cout_R5: assert (carry_out == 1'b0);
      if (func_sel == 3'b000) begin
        assert_const_zero_R1: assert (result == '0);
      end
      if (func_sel == 3'b111) begin
        assert_const_ones_R1: assert (result == '1);
      end
    end else begin
      if (func_sel[1:0] == 2'b00) begin
        assert_inc_R6: assert (got == ref_inc);
      end
      if (func_sel[1:0] == 2'b01) begin
        assert_add_R7: assert (got == ref_add);
      end
      if (func_sel[1:0] == 2'b10) begin
        assert_sub_borrow_R8: assert (carry_out == (opa >= opb));
        assert_sub_value_R8: assert (result == WIDTH'(opa - opb));
      end
      if (func_sel[1:0] == 2'b11) begin
        assert_dec_R9: assert (carry_out == (opa != '0));
      end
    end
  end

endmodule

bind mdsel_alu mdsel_alu_chk #(.WIDTH(WIDTH)) chk_i (
  .opa       (opa),
  .opb       (opb),
  .mode      (mode),
  .func_sel  (func_sel),
  .carry_in  (carry_in),
  .result    (result),
  .carry_out (carry_out)
);

// File: tb/mdsel_alu_tb_top.sv
module mdsel_alu_tb_top;

  localparam int W    = 4;
  localparam int SPAN = 1 << W;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] opa;
  logic [W-1:0] opb;
  logic         mode;
  logic [2:0]   func_sel;
  logic         carry_in;
  logic [W-1:0] result;
  logic         carry_out;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  mdsel_alu #(.WIDTH(W)) dut_i (
    .opa       (opa),
    .opb       (opb),
    .mode      (mode),
    .func_sel  (func_sel),
    .carry_in  (carry_in),
    .result    (result),
    .carry_out (carry_out)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [W:0] model(input logic m, input logic [2:0] s,
                                        input logic [W-1:0] a, input logic [W-1:0] b,
                                        input logic c);
    logic [W:0] wa;
    logic [W:0] wb;
    wa = {1'b0, a};
    wb = {1'b0, b};
    if (!m) begin
      case (s)
        3'b000:  return {1'b0, {W{1'b0}}};
        3'b001:  return {1'b0, a | b};
        3'b010:  return {1'b0, a & b};
        3'b011:  return {1'b0, ~a};
        3'b100:  return {1'b0, ~b};
        3'b101:  return {1'b0, ~(a & b)};
        3'b110:  return {1'b0, ~(a | b)};
        default: return {1'b0, {W{1'b1}}};
      endcase
    end
    case (s[1:0])
      2'b00:   return wa + (W+1)'(1);
      2'b01:   return wa + wb + {{W{1'b0}}, c};
      2'b10:   return wa + {1'b0, ~b} + (W+1)'(1);
      default: return wa + {1'b0, {W{1'b1}}};
    endcase
  endfunction

  task automatic chk(input string req, input logic [W:0] got, input logic [W:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got %h expected %h (mode=%b sel=%b a=%h b=%h cin=%b)",
               req, got, exp, mode, func_sel, opa, opb, carry_in);
    end
  endtask

  task automatic apply(input logic m, input logic [2:0] s, input logic [W-1:0] a,
                       input logic [W-1:0] b, input logic c);
    @(negedge clk);
    mode = m; func_sel = s; opa = a; opb = b; carry_in = c;
    #1;
  endtask

  // Sweeps every operand pair and both carry-in values for one operation
  task automatic sweep(input string req, input logic m, input logic [2:0] s);
    for (int ia = 0; ia < SPAN; ia++) begin
      for (int ib = 0; ib < SPAN; ib++) begin
        for (int ic = 0; ic < 2; ic++) begin
          apply(m, s, W'(ia), W'(ib), 1'(ic));
          chk(req, {carry_out, result}, model(m, s, W'(ia), W'(ib), 1'(ic)));
        end
      end
    end
  endtask

  task automatic test_reset;
    rst_n = 1'b0;
    apply(1'b0, 3'b000, '0, '0, 1'b0);
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 idle", {carry_out, result}, '0);
  endtask

  task automatic test_consts;      sweep("R1 zero", 1'b0, 3'b000); sweep("R1 ones", 1'b0, 3'b111); endtask
  task automatic test_or_and;      sweep("R2 or", 1'b0, 3'b001);   sweep("R2 and", 1'b0, 3'b010);  endtask
  task automatic test_nots;        sweep("R3 nota", 1'b0, 3'b011); sweep("R3 notb", 1'b0, 3'b100); endtask
  task automatic test_nand_nor;    sweep("R4 nand", 1'b0, 3'b101); sweep("R4 nor", 1'b0, 3'b110);  endtask

  // R5: carry out stays low and carry in is ignored in logic mode
  task automatic test_logic_carry;
    for (int s = 0; s < 8; s++) begin
      logic [W:0] r0;
      apply(1'b0, 3'(s), 4'hF, 4'hF, 1'b0);
      r0 = {carry_out, result};
      apply(1'b0, 3'(s), 4'hF, 4'hF, 1'b1);
      chk("R5 cin", {carry_out, result}, r0);
      chk("R5 cout", {W'(0), carry_out}, '0);
    end
  endtask

  task automatic test_inc;  sweep("R6 inc", 1'b1, 3'b000); endtask
  task automatic test_add;  sweep("R7 add", 1'b1, 3'b001); endtask
  task automatic test_sub;
    sweep("R8 sub", 1'b1, 3'b010);
    apply(1'b1, 3'b010, 4'h5, 4'h5, 1'b0);
    chk("R8 equal", {carry_out, result}, {1'b1, 4'h0});
    apply(1'b1, 3'b010, 4'h2, 4'h3, 1'b1);
    chk("R8 borrow", {carry_out, result}, {1'b0, 4'hF});
  endtask
  task automatic test_dec;
    sweep("R9 dec", 1'b1, 3'b011);
    apply(1'b1, 3'b011, 4'h0, 4'h0, 1'b1);
    chk("R9 wrap", {carry_out, result}, {1'b0, 4'hF});
  endtask

  // R10: the top select bit is ignored in arithmetic mode
  task automatic test_s2;
    for (int s = 0; s < 4; s++) begin
      for (int ia = 0; ia < SPAN; ia++) begin
        for (int ib = 0; ib < SPAN; ib++) begin
          logic [W:0] lo;
          apply(1'b1, {1'b0, 2'(s)}, W'(ia), W'(ib), 1'b1);
          lo = {carry_out, result};
          apply(1'b1, {1'b1, 2'(s)}, W'(ia), W'(ib), 1'b1);
          chk("R10 s2", {carry_out, result}, lo);
        end
      end
    end
  endtask

  initial begin
    mode = 1'b0; func_sel = '0; opa = '0; opb = '0; carry_in = 1'b0; rst_n = 1'b0;
    test_reset();
    test_consts();
    test_or_and();
    test_nots();
    test_nand_nor();
    test_logic_carry();
    test_inc();
    test_add();
    test_sub();
    test_dec();
    test_s2();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule